// File: doc/BRIEF.md
# Programmable Raster Sync Timing Generator

This block produces the horizontal and vertical sync pulses, a display-enable strobe and the current pixel and line positions for a raster display. A horizontal position counter runs once per pixel clock. It steps through four segments in a fixed order: visible pixels, then front porch, then sync, then back porch. Each time the horizontal counter wraps, the vertical position counter advances by one line. The vertical counter steps through the same four segments, counted in lines.

The length of every segment, horizontal and vertical, is held in a register that a CPU writes over a simple single-cycle bus, and the CPU can read each register back. Each new value is written to a staging copy. The counters use a working copy, which takes the staged values only at the start of a frame, so a write made part way through a frame never tears that frame. A retrace flag goes high whenever the horizontal position is outside the visible pixels. Software can poll this flag and write the frame buffer only while the beam is blanked.

Top module: `raster_timing`

## Requirements
- R1: `pix_x` counts from 0 to (H total − 1) and then returns to 0, where H total is the sum of the four horizontal lengths. `line_y` advances by one on each horizontal wrap and returns to 0 after (V total − 1).
- R2: Each axis runs its segments in the order visible, front porch, sync, back porch. `hsync` is asserted for exactly the pixels A+F to A+F+S−1, where A, F and S are the visible, front-porch and sync lengths. `vsync` follows the same rule, counted in lines.
- R3: `disp_en` is 1 exactly when `pix_x` < H visible and `line_y` < V visible.
- R4: `hretrace` is 1 exactly when `pix_x` ≥ H visible. It does not depend on the vertical position.
- R5: Register map on `cfg_addr`: 0 = H visible, 1 = H front porch, 2 = H sync, 3 = H back porch, 4 = V visible, 5 = V front porch, 6 = V sync, 7 = V back porch. A write with `cfg_we`=1 is stored at the clock edge. `cfg_rdata` shows the stored value of the register at `cfg_addr` combinationally.
- R6: A written value first affects timing on the first pixel of the next frame. The frame in progress completes with the old lengths.
- R7: A segment of length 0 is skipped. The period stays equal to the sum of the remaining segments, and the counters never stall.
- R8: After a synchronous active-low reset, registers 0..7 hold the parameter defaults (1920, 205, 50, 255, 1080, 2, 55, 2 unless overridden), and both counters are 0.
- R9: Parameter `SYNC_ACTIVE_HIGH` sets the asserted level of both sync outputs. The default of 1 means the asserted level is 1. A value of 0 makes the asserted level 0.
- R10: The time between successive sync assertions is H total clocks for `hsync` and H total × V total clocks for `vsync`. The asserted width is S clocks for `hsync` and S × H total clocks for `vsync`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index for write and readback |
| cfg_wdata | input | LEN_W | Write data (segment length) |
| cfg_rdata | output | LEN_W | Readback of the staged register at `cfg_addr` |
| hsync | output | 1 | Horizontal sync, polarity set by `SYNC_ACTIVE_HIGH` |
| vsync | output | 1 | Vertical sync, polarity set by `SYNC_ACTIVE_HIGH` |
| disp_en | output | 1 | High while both axes are in the visible segment |
| hretrace | output | 1 | High while the horizontal position is outside the visible pixels |
| pix_x | output | LEN_W+2 | Current horizontal position |
| line_y | output | LEN_W+2 | Current vertical position |

## Verification
The assertions assume that `cfg_addr` and `cfg_wdata` are stable while `cfg_we` is high. They also assume that the working lengths change only at a frame boundary, where both counters restart from 0. The bench drives the bus only between clock edges and gives each write a single clock cycle. It reprograms one instance in the middle of a frame, with a zero-length horizontal front porch and a zero-length vertical back porch. A second instance keeps the full-size defaults, and on it only line-level periods and widths are measured, so that every frame completes within the run.

// File: rtl/raster_pkg.sv
// raster_pkg: shared register indices and the segment type for the raster
// timing generator. Assumes eight timing registers in a fixed index order.
package raster_pkg;
    localparam int NUM_TIMING_REGS = 8;
    localparam int IDX_H_ACT  = 0;
    localparam int IDX_H_FP   = 1;
    localparam int IDX_H_SYNC = 2;
    localparam int IDX_H_BP   = 3;
    localparam int IDX_V_ACT  = 4;
    localparam int IDX_V_FP   = 5;
    localparam int IDX_V_SYNC = 6;
    localparam int IDX_V_BP   = 7;

    typedef enum logic [1:0] {
        SEG_ACTIVE = 2'd0,
        SEG_FRONT  = 2'd1,
        SEG_SYNC   = 2'd2,
        SEG_BACK   = 2'd3
    } seg_e;
endpackage

// File: rtl/raster_regs.sv
// raster_regs: staged timing registers written by the CPU, plus a working
// copy that the counters use. The working copy takes the staged values only
// on frame_start, i.e. the edge on which both counters wrap.
// Assumes frame_start is a single-cycle strobe from the counter logic.
module raster_regs
    import raster_pkg::*;
#(
    parameter int LEN_W = 12,
    parameter logic [NUM_TIMING_REGS*LEN_W-1:0] RESET_VALUES = '0,
    localparam int AW = $clog2(NUM_TIMING_REGS)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             we,
    input  logic [AW-1:0]                    addr,
    input  logic [LEN_W-1:0]                 wdata,
    output logic [LEN_W-1:0]                 rdata,
    input  logic                             frame_start,
    output logic [NUM_TIMING_REGS*LEN_W-1:0] working
);
    logic [LEN_W-1:0] staged [NUM_TIMING_REGS];

    genvar gi;
    generate
        for (gi = 0; gi < NUM_TIMING_REGS; gi++) begin : g_reg
            // Staged copy: reset to its default, loaded on a matching write.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    staged[gi] <= RESET_VALUES[gi*LEN_W +: LEN_W];
                else if (we && (addr == AW'(gi)))
                    staged[gi] <= wdata;
            end

            // Working copy: reset to the default, refreshed at frame start.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    working[gi*LEN_W +: LEN_W] <= RESET_VALUES[gi*LEN_W +: LEN_W];
                else if (frame_start)
                    working[gi*LEN_W +: LEN_W] <= staged[gi];
            end
        end
    endgenerate

    // Readback of the staged register selected by addr.
    always_comb rdata = staged[addr];

    AST_WORKING_FRAME_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(working)); // R6
endmodule

// File: rtl/raster_axis.sv
// raster_axis: one position counter with four-segment decode, used once per
// pixel for the horizontal axis and once per line for the vertical axis.
// Segment order is visible, front porch, sync, back porch. Lengths may be 0.
// Assumes the lengths change only on an edge where this counter wraps.
module raster_axis
    import raster_pkg::*;
#(
    parameter int LEN_W = 12,
    localparam int POS_W = LEN_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [LEN_W-1:0] len_act,
    input  logic [LEN_W-1:0] len_fp,
    input  logic [LEN_W-1:0] len_sync,
    input  logic [LEN_W-1:0] len_bp,
    output logic [POS_W-1:0] pos,
    output logic             in_act,
    output logic             in_sync,
    output logic             wrap
);
    logic [POS_W-1:0] end_act, end_fp, end_sync, total;
    seg_e             seg;

    // Cumulative segment boundaries; a zero length gives an empty range.
    always_comb begin
        end_act  = POS_W'(len_act);
        end_fp   = end_act + POS_W'(len_fp);
        end_sync = end_fp + POS_W'(len_sync);
        total    = end_sync + POS_W'(len_bp);
    end

    // Segment decode from the current position.
    always_comb begin
        if (pos < end_act)       seg = SEG_ACTIVE;
        else if (pos < end_fp)   seg = SEG_FRONT;
        else if (pos < end_sync) seg = SEG_SYNC;
        else                     seg = SEG_BACK;
        in_act  = (seg == SEG_ACTIVE);
        in_sync = (seg == SEG_SYNC);
    end

    // Wrap strobe on the last position of the period.
    always_comb wrap = step && ((pos + POS_W'(1)) >= total);

    // Position counter: advance on step, return to zero on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)    pos <= '0;
        else if (wrap) pos <= '0;
        else if (step) pos <= pos + POS_W'(1);
    end

    AST_POS_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (total == '0) || (pos < total)); // R1
    AST_WRAP_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (pos == '0)); // R1
    AST_HOLD_WITHOUT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(pos)); // R7
endmodule

// File: rtl/raster_timing.sv
// raster_timing: programmable raster sync generator. Combines the register
// bank with a horizontal and a vertical axis counter, and derives the sync,
// display-enable and retrace outputs. Assumes clk is the pixel clock.
module raster_timing
    import raster_pkg::*;
#(
    parameter int LEN_W            = 12,
    parameter bit SYNC_ACTIVE_HIGH = 1'b1,
    parameter int DEF_H_ACT        = 1920,
    parameter int DEF_H_FP         = 205,
    parameter int DEF_H_SYNC       = 50,
    parameter int DEF_H_BP         = 255,
    parameter int DEF_V_ACT        = 1080,
    parameter int DEF_V_FP         = 2,
    parameter int DEF_V_SYNC       = 55,
    parameter int DEF_V_BP         = 2,
    localparam int POS_W           = LEN_W + 2,
    localparam int AW              = $clog2(NUM_TIMING_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [AW-1:0]    cfg_addr,
    input  logic [LEN_W-1:0] cfg_wdata,
    output logic [LEN_W-1:0] cfg_rdata,
    output logic             hsync,
    output logic             vsync,
    output logic             disp_en,
    output logic             hretrace,
    output logic [POS_W-1:0] pix_x,
    output logic [POS_W-1:0] line_y
);
    localparam logic [NUM_TIMING_REGS*LEN_W-1:0] RESET_VALUES = {
        LEN_W'(DEF_V_BP), LEN_W'(DEF_V_SYNC), LEN_W'(DEF_V_FP), LEN_W'(DEF_V_ACT),
        LEN_W'(DEF_H_BP), LEN_W'(DEF_H_SYNC), LEN_W'(DEF_H_FP), LEN_W'(DEF_H_ACT)};

    logic [NUM_TIMING_REGS*LEN_W-1:0] working;
    logic h_act, h_sync, h_wrap;
    logic v_act, v_sync, v_wrap;
    logic frame_start;

    // Frame boundary: last pixel of the last line.
    always_comb frame_start = h_wrap && v_wrap;

    raster_regs #(.LEN_W(LEN_W), .RESET_VALUES(RESET_VALUES)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .rdata(cfg_rdata), .frame_start(frame_start),
        .working(working));

    raster_axis #(.LEN_W(LEN_W)) u_horiz (
        .clk(clk), .rst_n(rst_n), .step(1'b1),
        .len_act (working[IDX_H_ACT*LEN_W  +: LEN_W]),
        .len_fp  (working[IDX_H_FP*LEN_W   +: LEN_W]),
        .len_sync(working[IDX_H_SYNC*LEN_W +: LEN_W]),
        .len_bp  (working[IDX_H_BP*LEN_W   +: LEN_W]),
        .pos(pix_x), .in_act(h_act), .in_sync(h_sync), .wrap(h_wrap));

    raster_axis #(.LEN_W(LEN_W)) u_vert (
        .clk(clk), .rst_n(rst_n), .step(h_wrap),
        .len_act (working[IDX_V_ACT*LEN_W  +: LEN_W]),
        .len_fp  (working[IDX_V_FP*LEN_W   +: LEN_W]),
        .len_sync(working[IDX_V_SYNC*LEN_W +: LEN_W]),
        .len_bp  (working[IDX_V_BP*LEN_W   +: LEN_W]),
        .pos(line_y), .in_act(v_act), .in_sync(v_sync), .wrap(v_wrap));

    // Output decode: polarity, display enable and the retrace flag.
    always_comb begin
        hsync    = SYNC_ACTIVE_HIGH ? h_sync : !h_sync;
        vsync    = SYNC_ACTIVE_HIGH ? v_sync : !v_sync;
        disp_en  = h_act && v_act;
        hretrace = !h_act;
    end

    AST_SYNC_BLANKED: assert property (@(posedge clk) disable iff (!rst_n)
        (hsync == SYNC_ACTIVE_HIGH) |-> (hretrace && !disp_en)); // R2
    AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_x != '0) |=> ($stable(line_y) || (pix_x == '0))); // R1
endmodule

// File: tb/raster_timing_test.sv
module raster_timing_test;
    localparam int LW = 12;
    localparam int PW = LW + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // Instance with full-size defaults and active-high sync.
    logic [2:0]    d_addr = '0;
    logic [LW-1:0] d_rdata;
    logic          d_hs, d_vs, d_de, d_hr;
    logic [PW-1:0] d_x, d_y;

    raster_timing uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(1'b0), .cfg_addr(d_addr),
        .cfg_wdata('0), .cfg_rdata(d_rdata), .hsync(d_hs), .vsync(d_vs),
        .disp_en(d_de), .hretrace(d_hr), .pix_x(d_x), .line_y(d_y));

    // Small-frame instance with active-low sync, checked against the model.
    logic          f_we = 1'b0;
    logic [2:0]    f_addr = '0;
    logic [LW-1:0] f_wdata = '0;
    logic [LW-1:0] f_rdata;
    logic          f_hs, f_vs, f_de, f_hr;
    logic [PW-1:0] f_x, f_y;

    raster_timing #(
        .LEN_W(LW), .SYNC_ACTIVE_HIGH(1'b0),
        .DEF_H_ACT(16), .DEF_H_FP(2), .DEF_H_SYNC(3), .DEF_H_BP(3),
        .DEF_V_ACT(5), .DEF_V_FP(1), .DEF_V_SYNC(2), .DEF_V_BP(1)
    ) uut_fast (
        .clk(clk), .rst_n(rst_n), .cfg_we(f_we), .cfg_addr(f_addr),
        .cfg_wdata(f_wdata), .cfg_rdata(f_rdata), .hsync(f_hs), .vsync(f_vs),
        .disp_en(f_de), .hretrace(f_hr), .pix_x(f_x), .line_y(f_y));

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural model of the small-frame instance.
    int fdef[8] = '{16, 2, 3, 3, 5, 1, 2, 1};
    int prog[8];
    int cur[8];
    int hp, vp;

    always @(posedge clk) begin : model
        int oldp[8];
        int ht, vt;
        if (!rst_n) begin
            hp = 0; vp = 0;
            prog = fdef; cur = fdef;
        end else begin
            oldp = prog;
            if (f_we) prog[f_addr] = int'(f_wdata);
            ht = cur[0] + cur[1] + cur[2] + cur[3];
            vt = cur[4] + cur[5] + cur[6] + cur[7];
            if (hp + 1 >= ht) begin
                hp = 0;
                if (vp + 1 >= vt) begin
                    vp = 0;
                    cur = oldp;
                end else vp++;
            end else hp++;
        end
    end

    // Compare the small-frame instance with the model every clock.
    always @(negedge clk) begin : compare
        int hs0, vs0;
        if (rst_n && !done) begin
            hs0 = cur[0] + cur[1];
            vs0 = cur[4] + cur[5];
            chk("R1 pix_x", int'(f_x), hp);
            chk("R1 line_y", int'(f_y), vp);
            chk("R2/R9 hsync", int'(f_hs), (hp >= hs0 && hp < hs0 + cur[2]) ? 0 : 1);
            chk("R2/R9 vsync", int'(f_vs), (vp >= vs0 && vp < vs0 + cur[6]) ? 0 : 1);
            chk("R3 disp_en", int'(f_de), (hp < cur[0] && vp < cur[4]) ? 1 : 0);
            chk("R4 hretrace", int'(f_hr), (hp >= cur[0]) ? 1 : 0);
            chk("R5 readback", int'(f_rdata), prog[f_addr]);
        end
    end

    // Asserted state of a chosen signal: 0 hsync, 1 vsync, 2 visible pixel.
    function automatic bit sig_on(input int inst, input int which);
        if (inst == 0)
            return (which == 0) ? d_hs : (which == 1) ? d_vs : !d_hr;
        return (which == 0) ? !f_hs : (which == 1) ? !f_vs : !f_hr;
    endfunction

    // Period between assertions and width of one assertion, in clocks.
    task automatic measure(input int inst, input int which,
                           output int period, output int width);
        bit prev, now;
        int n;
        prev = sig_on(inst, which);
        forever begin
            @(negedge clk);
            now = sig_on(inst, which);
            if (now && !prev) break;
            prev = now;
        end
        n = 0; width = 0; prev = 1'b1;
        forever begin
            @(negedge clk);
            n++;
            now = sig_on(inst, which);
            if (now && width == 0 && !prev) begin end
            if (!now && width == 0) width = n;
            if (now && !prev) break;
            prev = now;
        end
        period = n;
    endtask

    task automatic wait_frame();
        do @(negedge clk); while (!(f_x == '0 && f_y == '0));
    endtask

    task automatic fwrite(input int a, input int d);
        @(negedge clk); #2;
        f_we = 1'b1; f_addr = 3'(a); f_wdata = LW'(d);
        @(negedge clk); #2;
        f_we = 1'b0; f_addr = '0;
    endtask

    initial begin : watchdog
        #(20 * 190000);
        if (!done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        int per, wid;
        int dexp[8] = '{1920, 205, 50, 255, 1080, 2, 55, 2};
        int nv[8] = '{10, 0, 2, 4, 4, 1, 1, 0};
        repeat (3) @(negedge clk);
        // R8: reset state of the default instance
        chk("R8 pix_x at reset", int'(d_x), 0);
        chk("R8 line_y at reset", int'(d_y), 0);
        for (int i = 0; i < 8; i++) begin
            d_addr = 3'(i); #1;
            chk("R8 default register", int'(d_rdata), dexp[i]);
        end
        d_addr = '0;
        @(negedge clk); #2;
        rst_n = 1'b1;

        // R10, R2, R9: default line timing, active-high sync
        measure(0, 0, per, wid);
        chk("R10 default hsync period", per, 2430);
        chk("R2 default hsync width", wid, 50);
        measure(0, 2, per, wid);
        chk("R4 default visible period", per, 2430);
        chk("R4 default visible width", wid, 1920);

        // R10, R9: small-frame defaults, active-low sync
        measure(1, 0, per, wid);
        chk("R10 fast hsync period", per, 24);
        chk("R9 fast hsync low width", wid, 3);
        measure(1, 1, per, wid);
        chk("R10 fast vsync period", per, 216);
        chk("R10 fast vsync low width", wid, 48);

        // R6: reprogram mid-frame; current frame keeps old lengths
        wait_frame();
        for (int i = 0; i < 8; i++) fwrite(i, nv[i]);
        measure(1, 0, per, wid);
        chk("R6 old hsync period kept", per, 24);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); #2; f_addr = 3'(i); #1;
            chk("R5 readback after write", int'(f_rdata), nv[i]);
        end
        f_addr = '0;

        // R7: zero front porch and zero back porch take effect next frame
        wait_frame();
        measure(1, 0, per, wid);
        chk("R7 new hsync period", per, 16);
        chk("R7 new hsync width", wid, 2);
        measure(1, 1, per, wid);
        chk("R7 new vsync period", per, 96);
        chk("R7 new vsync width", wid, 16);
        measure(1, 2, per, wid);
        chk("R3 new visible width", wid, 10);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule